// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns bytes into asynchronous serial frames on a single transmit line. A byte enters through a valid/ready stream port and waits in a one-entry holding register. From there it moves into a frame sequencer. The sequencer sends a low start bit, then the data bits least significant first, then an optional parity bit, then one or more high stop bits. Bit timing comes from an external enable that pulses at sixteen times the bit rate, and every bit lasts sixteen of those pulses.

The frame format is read from a 7-bit line-control input. It selects the word length (5 to 8 bits), the parity mode (odd, even, forced one or forced zero) and the number of stop bits. The block copies the format when a frame starts, so the format can change while a frame is on the line. A break bit forces the line low for as long as it is set. Two status outputs report that the holding register is empty and that the transmitter is completely idle.

Back-pressure rules: `in_ready` is high exactly while the holding register is empty. A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, `in_valid` and `in_data` are ignored. The producer may hold `in_valid` high for as long as it likes without losing data.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset, `txd` is 1, and `in_ready`, `hold_empty` and `tx_idle` are all 1.
- R2: `in_ready` and `hold_empty` are high exactly while the holding register is empty. A byte is taken only when `in_valid` and `in_ready` are both high at a clock edge. A valid byte offered while the register is full is ignored and never sent.
- R3: A frame is a low start bit, then the data bits with bit 0 first, then an optional parity bit, then high stop bits. Every start, data and parity bit lasts 16 `baud_tick` pulses. The start bit begins on the clock edge where the byte leaves the holding register.
- R4: `line_ctl[1:0]` sets the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the word length are not sent.
- R5: `line_ctl[3]` = 1 adds a parity bit. `line_ctl[5:4]` then selects the mode: 0 = odd (data bits plus parity bit hold an odd number of ones), 1 = even, 2 = always 1, 3 = always 0.
- R6: `line_ctl[2]` = 0 gives a stop period of 16 ticks. `line_ctl[2]` = 1 gives 32 ticks.
- R7: With a 5-bit word and `line_ctl[2]` = 1, the stop period is 24 ticks, which is one and a half bits.
- R8: While `line_ctl[6]` = 1, `txd` is 0. Frame timing keeps running underneath the break.
- R9: If a byte is waiting when the last stop tick arrives, its start bit begins on that same edge, with no idle time between the frames.
- R10: `tx_idle` is high only while the holding register is empty and no frame is in progress. While it is high and no break is set, `txd` is 1.
- R11: The format is copied from `line_ctl[5:0]` when a frame starts. Changing it during the frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| line_ctl | input | 7 | [1:0] word length, [2] two stop bits, [3] parity enable, [5:4] parity mode, [6] break |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Holding register can take a byte |
| txd | output | 1 | Serial transmit line, idles high |
| hold_empty | output | 1 | Status: holding register empty |
| tx_idle | output | 1 | Status: holding register and shifter both empty |

## Verification
The bench targets the handover between frames. A design that inserted an idle tick there, or that loaded a byte during the parity bit, would shift every following bit. It sends 5-bit words with two stop bits, where a stop period of a whole 32 ticks would show as a late `tx_idle`. It also sends each of the four parity modes, where an inverted odd/even choice would flip the parity bit. Two further cases check that a late change to `line_ctl` does not leak into a running frame, and that a byte offered while the holding register is full is dropped and not overwritten into it. Break is raised in the middle of a frame, and the bench checks that the line returns to the point the frame has reached.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [1:0] {
    PAR_ODD  = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ONE  = 2'd2,
    PAR_ZERO = 2'd3
  } par_mode_e;

  typedef struct packed {
    logic [1:0] wlen;      // word length minus five
    logic       two_stop;
    logic       par_en;
    par_mode_e  par_mode;
  } frame_cfg_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_START, SQ_DATA, SQ_PAR, SQ_STOP
  } seq_state_e;

  // Parity bit over the low (5 + wlen) bits of a data word.
  function automatic logic calc_parity(input logic [7:0] d, input frame_cfg_t c);
    logic [7:0] mask;
    logic       ones;
    mask = 8'hFF >> (3 - c.wlen);
    ones = ^(d & mask);
    case (c.par_mode)
      PAR_ODD:  calc_parity = ~ones;
      PAR_EVEN: calc_parity = ones;
      PAR_ONE:  calc_parity = 1'b1;
      default:  calc_parity = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          take,
  output logic          in_ready,
  output logic          full,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (in_valid && !full) begin
      full <= 1'b1;
      data <= in_data;
    end
  end

  assign in_ready = !full;
endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
  import uart_tx_pkg::*;
#(
  parameter int DW = 8,
  parameter int OS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  input  frame_cfg_t    cfg,
  output logic          take,
  output logic          line,
  output logic          busy
);
  localparam int CW    = $clog2(2 * OS);
  localparam int BW    = $clog2(DW);
  localparam int STOP1 = OS;
  localparam int STOP2 = 2 * OS;
  localparam int STOPH = OS + OS / 2;

  seq_state_e    st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW-1:0] shreg;
  frame_cfg_t    cfg_q;
  logic          par_q;
  logic [CW:0]   seg_len;
  logic [BW-1:0] last_bit;
  logic          seg_last;

  always_comb begin
    if (st != SQ_STOP)            seg_len = (CW+1)'(STOP1);
    else if (!cfg_q.two_stop)     seg_len = (CW+1)'(STOP1);
    else if (cfg_q.wlen == 2'd0)  seg_len = (CW+1)'(STOPH);
    else                          seg_len = (CW+1)'(STOP2);
  end

  assign last_bit = BW'(4 + cfg_q.wlen);
  assign seg_last = tick && ({1'b0, cnt} == seg_len - 1'b1);
  assign take     = hold_full && ((st == SQ_IDLE) || (st == SQ_STOP && seg_last));
  assign busy     = (st != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SQ_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
      cfg_q <= '0;
      par_q <= 1'b0;
      line  <= 1'b1;
    end else if (take) begin
      st    <= SQ_START;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= hold_data;
      cfg_q <= cfg;
      par_q <= calc_parity(hold_data, cfg);
      line  <= 1'b0;
    end else if (st != SQ_IDLE && tick) begin
      if (!seg_last) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (st)
          SQ_START: begin
            st   <= SQ_DATA;
            line <= shreg[0];
          end
          SQ_DATA: begin
            if (bitn == last_bit) begin
              st   <= cfg_q.par_en ? SQ_PAR : SQ_STOP;
              line <= cfg_q.par_en ? par_q : 1'b1;
            end else begin
              bitn  <= bitn + 1'b1;
              shreg <= shreg >> 1;
              line  <= shreg[1];
            end
          end
          SQ_PAR: begin
            st   <= SQ_STOP;
            line <= 1'b1;
          end
          default: begin
            st   <= SQ_IDLE;
            line <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DW = 8,
  parameter int OS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic [6:0]    line_ctl,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          txd,
  output logic          hold_empty,
  output logic          tx_idle
);
  frame_cfg_t    cfg;
  logic          take;
  logic          full;
  logic [DW-1:0] hdata;
  logic          line;
  logic          busy;

  assign cfg.wlen     = line_ctl[1:0];
  assign cfg.two_stop = line_ctl[2];
  assign cfg.par_en   = line_ctl[3];
  assign cfg.par_mode = par_mode_e'(line_ctl[5:4]);

  uart_tx_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .take(take), .in_ready(in_ready), .full(full), .data(hdata)
  );

  uart_tx_seq #(.DW(DW), .OS(OS)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .hold_full(full),
    .hold_data(hdata), .cfg(cfg), .take(take), .line(line), .busy(busy)
  );

  assign txd        = line & ~line_ctl[6];
  assign hold_empty = !full;
  assign tx_idle    = !full && !busy;
endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic brk,
  input logic txd,
  input logic tx_idle
);
  // R10: full idle implies the holding register is free
  a_r10_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> in_ready);
  // R10: idle line sits high unless break is set
  a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_idle && !brk) |-> txd);
  // R8: break forces the line low
  a_r8_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd);
  // R2: an accepted byte fills the holding register
  a_r2_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  // R9: the holding register empties only into a running frame
  a_r9_load_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> !tx_idle);
endmodule

bind uart_tx_framer uart_tx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .brk(line_ctl[6]), .txd(txd), .tx_idle(tx_idle)
);

// File: tb/sim_uart_tx_framer.sv
module sim_uart_tx_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [6:0] line_ctl = 7'h03;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, txd, hold_empty, tx_idle;

  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  int    tph = 0;
  string cur_req = "R1";

  // reference model state
  bit   m_full = 0;
  bit   m_busy = 0;
  logic [7:0] m_data = 0;
  int   lvl[$];
  int   dur[$];

  uart_tx_framer u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .line_ctl(line_ctl),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .txd(txd),
    .hold_empty(hold_empty), .tx_idle(tx_idle)
  );

  always #10 clk = ~clk;

  function automatic logic [6:0] fmt(int wl, int two, int pe, int pm, int brk);
    return 7'((brk << 6) | (pm << 4) | (pe << 3) | (two << 2) | wl);
  endfunction

  function automatic void build(logic [7:0] d, logic [6:0] c);
    int n;
    int ones;
    int p;
    n = 5 + c[1:0];
    ones = 0;
    lvl.push_back(0); dur.push_back(16);
    for (int i = 0; i < n; i++) begin
      lvl.push_back(d[i]); dur.push_back(16);
      ones += d[i];
    end
    if (c[3]) begin
      case (c[5:4])
        2'd0: p = (ones % 2 == 0) ? 1 : 0;
        2'd1: p = ones % 2;
        2'd2: p = 1;
        default: p = 0;
      endcase
      lvl.push_back(p); dur.push_back(16);
    end
    lvl.push_back(1);
    dur.push_back(!c[2] ? 16 : (n == 5 ? 24 : 32));
  endfunction

  // tick source, driven away from the edge
  always @(posedge clk) begin
    #5;
    tph = tph + 1;
    baud_tick = (tph % 3 == 0) || (tph % 7 == 0);
  end

  // model update at the edge, from inputs that settled earlier
  always @(posedge clk) begin
    bit pre_full, pre_busy, ended;
    cyc++;
    if (!rst_n) begin
      m_full = 0; m_busy = 0; lvl.delete(); dur.delete();
    end else begin
      pre_full = m_full; pre_busy = m_busy; ended = 0;
      if (m_busy && baud_tick) begin
        dur[0] = dur[0] - 1;
        if (dur[0] == 0) begin
          void'(lvl.pop_front()); void'(dur.pop_front());
          if (lvl.size() == 0) begin m_busy = 0; ended = 1; end
        end
      end
      if (pre_full && (!pre_busy || ended)) begin
        build(m_data, line_ctl);
        m_busy = 1; m_full = 0;
      end else if (in_valid && !pre_full) begin
        m_full = 1; m_data = in_data;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // compare on every clock, at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "txd", txd, (m_busy ? lvl[0] : 1) & !line_ctl[6]);
      chk("R2", "in_ready", in_ready, !m_full);
      chk("R2", "hold_empty", hold_empty, !m_full);
      chk("R10", "tx_idle", tx_idle, !m_full && !m_busy);
    end
  end

  task automatic drive_wait();
    @(posedge clk); #5;
  endtask

  task automatic send(logic [7:0] d);
    while (!in_ready) drive_wait();
    in_valid = 1'b1; in_data = d;
    drive_wait();
    in_valid = 1'b0; in_data = 8'h00;
  endtask

  task automatic wait_idle();
    drive_wait();
    while (!tx_idle) drive_wait();
    repeat (3) drive_wait();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #3;
    // R1: reset state
    chk("R1", "txd", txd, 1);
    chk("R1", "in_ready", in_ready, 1);
    chk("R1", "hold_empty", hold_empty, 1);
    chk("R1", "tx_idle", tx_idle, 1);
    drive_wait();
    rst_n = 1'b1;
    repeat (2) drive_wait();

    cur_req = "R3";
    line_ctl = fmt(3, 0, 0, 0, 0);
    send(8'hA5); wait_idle();
    send(8'h3C); wait_idle();

    cur_req = "R4";
    for (int w = 0; w < 3; w++) begin
      line_ctl = fmt(w, 0, 0, 0, 0);
      send(8'hE3); wait_idle();
    end

    cur_req = "R5";
    for (int pm = 0; pm < 4; pm++) begin
      line_ctl = fmt(2, 0, 1, pm, 0);
      send(8'h5B); wait_idle();
      line_ctl = fmt(3, 0, 1, pm, 0);
      send(8'h81); wait_idle();
    end

    cur_req = "R6";
    line_ctl = fmt(3, 1, 0, 0, 0);
    send(8'h0F); wait_idle();
    line_ctl = fmt(1, 1, 1, 1, 0);
    send(8'h2A); wait_idle();

    cur_req = "R7";
    line_ctl = fmt(0, 1, 0, 0, 0);
    send(8'h15); wait_idle();
    line_ctl = fmt(0, 1, 1, 0, 0);
    send(8'h1F); wait_idle();

    cur_req = "R9";
    line_ctl = fmt(3, 0, 1, 1, 0);
    send(8'h11); send(8'hC4); send(8'h7E); wait_idle();

    // R2: a byte offered while the holding register is full is dropped
    cur_req = "R2";
    line_ctl = fmt(3, 0, 0, 0, 0);
    send(8'h99); send(8'h66);
    in_valid = 1'b1; in_data = 8'hFF;
    drive_wait();
    chk("R2", "ready while full", in_ready, 0);
    in_valid = 1'b0;
    wait_idle();

    // R11: format change during a frame
    cur_req = "R11";
    line_ctl = fmt(3, 0, 0, 0, 0);
    send(8'hB2);
    repeat (20) drive_wait();
    line_ctl = fmt(0, 1, 1, 2, 0);
    wait_idle();

    // R8: break in the middle of a frame and while idle
    cur_req = "R8";
    line_ctl = fmt(3, 0, 1, 0, 0);
    send(8'h4D);
    repeat (60) drive_wait();
    line_ctl = fmt(3, 0, 1, 0, 1);
    repeat (90) drive_wait();
    line_ctl = fmt(3, 0, 1, 0, 0);
    wait_idle();
    line_ctl = fmt(3, 0, 0, 0, 1);
    repeat (10) drive_wait();
    chk("R8", "idle break", txd, 0);
    line_ctl = fmt(3, 0, 0, 0, 0);
    repeat (5) drive_wait();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule